// File: doc/BRIEF.md
# Byte-Addressed Memory Target on a Two-Wire Serial Bus

This block is a two-wire serial bus (I2C) target that looks to a bus master like a small serial memory. It watches the clock line and the data line through synchronizers clocked by a fast system clock. It answers on the data line only by pulling it low through an output enable, so the line stays open-drain. The block holds a fixed 7-bit device address, a word address of one or two bytes, an internal byte array and one address pointer.

The pointer keeps its value from one transaction to the next and steps by one after every byte stored or returned. The master sets the pointer with a write-direction header followed by the word address, and may then send data. It can also issue a new start, with or without a stop before it, and read from the pointer. A read-direction header with no address phase reads from wherever the last access left the pointer.

A read keeps returning bytes while the master acknowledges each one. `MEM_DEPTH` must be a power of two, and the pointer wraps at that depth.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset `sda_oe` is 0, every memory byte reads as 0 and the pointer is 0.
- R2: With SCL high, SDA falling is a start and SDA rising is a stop. A start at any point, including inside a transaction, begins a new header byte.
- R3: The first byte after a start carries the device address in bits 7..1, sent MSB first, and the direction in bit 0 (0 = write, 1 = read). A matching header is acknowledged by holding SDA low in the ninth clock.
- R4: A header whose address differs from `DEV_ADDR` gets no acknowledge. SDA then stays released until the next start or stop, even if further bytes are clocked.
- R5: In a write, the next `WORD_ADDR_BYTES` bytes are the word address, high byte first. Each is acknowledged, and the pointer is loaded with the address modulo `MEM_DEPTH`.
- R6: Every later byte of a write is stored at the pointer and acknowledged, and the pointer then increments. This continues for any byte count until a stop.
- R7: In a read, the target drives the byte at the pointer MSB first and then increments the pointer. It sends the next byte when the master acknowledges.
- R8: After the master gives a not-acknowledge, the target keeps SDA released for any further clocks until a start or stop.
- R9: A read header with no address phase returns data from the pointer as the previous transaction left it.
- R10: A random read, meaning a write header and word address followed by a read header, works whether or not a stop comes before the second start.
- R11: The pointer wraps from `MEM_DEPTH-1` to 0, both on stores and on reads.
- R12: `sda_oe` never changes while SCL stays high. It changes only after a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A data byte's store and the pointer wrap from the top address to zero happen on the same system clock edge. A page write that begins at the last address provokes this collision. The bench judges it by reading back both the last address and address zero, and by checking that a following current-address read returns address two. Random page writes, random reads with and without a stop, and current-address reads run against a bench model of the array and pointer. A monitor on the port checks that the output enable never moves while SCL is high.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_SKIP
  } tgt_state_t;

  typedef enum logic [1:0] {
    RX_HDR, RX_AHI, RX_ALO, RX_DATA
  } rx_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_l,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_hi,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_hi    = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_hi & ~scl_prev;
  assign scl_fall  = ~scl_hi & scl_prev;
  assign start_det = scl_hi & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_hi & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_l,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR        = 7'h50,
  parameter int         WORD_ADDR_BYTES = 2,
  parameter int         MEM_DEPTH       = 256,
  parameter int         SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PW   = $clog2(MEM_DEPTH);
  localparam int CNTW = 4;
  localparam logic [CNTW-1:0] BITS_PER_BYTE = CNTW'(8);
  localparam logic [CNTW-1:0] LAST_TX_BIT   = CNTW'(7);
  localparam rx_kind_t FIRST_ADDR = (WORD_ADDR_BYTES == 2) ? RX_AHI : RX_ALO;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_l = rst_pipe[1];

  logic scl_hi, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_l(rst_l), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_hi(scl_hi), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_t      st_q, st_d;
  rx_kind_t        kind_q, kind_d;
  logic [CNTW-1:0] bitcnt_q, bitcnt_d;
  logic [7:0]      shreg_q, shreg_d, ahi_q, ahi_d, mem_rdata;
  logic [PW-1:0]   ptr_q, ptr_d;
  logic            rd_q, rd_d, oe_q, oe_d, mack_q, mack_d, mem_we;

  i2c_mem_array #(.DEPTH(MEM_DEPTH), .AW(PW), .DW(8)) u_mem (
    .clk(clk), .rst_l(rst_l), .we(mem_we), .addr(ptr_q),
    .wdata(shreg_q), .rdata(mem_rdata)
  );

  always_comb begin
    st_d = st_q; kind_d = kind_q; bitcnt_d = bitcnt_q; shreg_d = shreg_q;
    ahi_d = ahi_q; ptr_d = ptr_q; rd_d = rd_q; oe_d = oe_q; mack_d = mack_q;
    mem_we = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_det) begin
      st_d = ST_RX; kind_d = RX_HDR; bitcnt_d = '0; oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && bitcnt_q < BITS_PER_BYTE) begin
            shreg_d  = {shreg_q[6:0], sda_lvl};
            bitcnt_d = bitcnt_q + CNTW'(1);
          end else if (scl_fall && bitcnt_q == BITS_PER_BYTE) begin
            st_d = ST_RXACK;
            oe_d = 1'b1;
            case (kind_q)
              RX_HDR: begin
                if (shreg_q[7:1] != DEV_ADDR) begin
                  st_d = ST_SKIP;
                  oe_d = 1'b0;
                end else begin
                  rd_d = shreg_q[0];
                end
              end
              RX_AHI: ahi_d = shreg_q;
              RX_ALO: ptr_d = PW'({ahi_q, shreg_q});
              default: begin
                mem_we = 1'b1;
                ptr_d  = ptr_q + PW'(1);
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (scl_fall) begin
            oe_d     = 1'b0;
            bitcnt_d = '0;
            if (kind_q == RX_HDR && rd_q) begin
              st_d    = ST_TX;
              shreg_d = mem_rdata;
              ptr_d   = ptr_q + PW'(1);
              oe_d    = ~mem_rdata[7];
            end else begin
              st_d = ST_RX;
              case (kind_q)
                RX_HDR:  kind_d = FIRST_ADDR;
                RX_AHI:  kind_d = RX_ALO;
                default: kind_d = RX_DATA;
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == LAST_TX_BIT) begin
              st_d = ST_TXACK;
              oe_d = 1'b0;
            end else begin
              shreg_d  = {shreg_q[6:0], 1'b0};
              bitcnt_d = bitcnt_q + CNTW'(1);
              oe_d     = ~shreg_q[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          if (scl_fall) begin
            if (mack_q) begin
              st_d     = ST_TX;
              bitcnt_d = '0;
              shreg_d  = mem_rdata;
              ptr_d    = ptr_q + PW'(1);
              oe_d     = ~mem_rdata[7];
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q <= ST_IDLE; kind_q <= RX_HDR; bitcnt_q <= '0; shreg_q <= '0;
      ahi_q <= '0; ptr_q <= '0; rd_q <= 1'b0; oe_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; bitcnt_q <= bitcnt_d; shreg_q <= shreg_d;
      ahi_q <= ahi_d; ptr_q <= ptr_d; rd_q <= rd_d; oe_q <= oe_d; mack_q <= mack_d;
    end
  end

  assign sda_oe = oe_q;

  AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_l)
    (scl_hi && !scl_rise && !start_det && !stop_det) |=> $stable(sda_oe)) else $error("oe moved with scl high"); // R12
  AST_SKIP_RELEASED: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_SKIP) |-> !sda_oe) else $error("driving while skipping"); // R4
  AST_PTR_STEP_ON_STORE: assert property (@(posedge clk) disable iff (!rst_l)
    mem_we |=> (ptr_q == $past(ptr_q) + PW'(1))) else $error("pointer did not step"); // R6
  AST_TX_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_l)
    (st_q == ST_TX) |-> rd_q) else $error("transmit without read header"); // R7
  AST_OE_ONLY_ACK_OR_TX: assert property (@(posedge clk) disable iff (!rst_l)
    sda_oe |-> (st_q == ST_RXACK || st_q == ST_TX)) else $error("oe outside ack/transmit"); // R8
endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, sda_oe, sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_target #(.DEV_ADDR(DEV), .WORD_ADDR_BYTES(2), .MEM_DEPTH(256)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0, viol = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  function automatic logic [7:0] fold_addr(input logic [15:0] a);
    return a[7:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R12 monitor: oe must not move while scl stays high
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (scl_m && prev_scl && sda_oe !== prev_oe) viol++;
      prev_scl = scl_m;
      prev_oe  = sda_oe;
    end
  end

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic m_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q();
    acked = ~sda_line;
    q(); scl_m = 1'b0; q();
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
    end
    q(); sda_m = ~give_ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  task automatic page_write(input logic [15:0] a, input int n);
    logic ak;
    m_start();
    wbyte({DEV, 1'b0}, ak); chk("R3 write header ack", ak, 1);
    wbyte(a[15:8], ak);     chk("R5 addr high ack", ak, 1);
    wbyte(a[7:0], ak);      chk("R5 addr low ack", ak, 1);
    ref_ptr = fold_addr(a);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wbyte(d, ak); chk("R6 data ack", ak, 1);
      ref_mem[ref_ptr] = d;
      ref_ptr = ref_ptr + 8'd1;
    end
    m_stop();
  endtask

  task automatic read_seq(input int n, input string tag);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, b);
      chk(tag, b, ref_mem[ref_ptr]);
      ref_ptr = ref_ptr + 8'd1;
    end
  endtask

  task automatic random_read(input logic [15:0] a, input int n, input logic with_stop);
    logic ak;
    m_start();
    wbyte({DEV, 1'b0}, ak); chk("R3 dummy header ack", ak, 1);
    wbyte(a[15:8], ak);     chk("R5 addr high ack", ak, 1);
    wbyte(a[7:0], ak);      chk("R5 addr low ack", ak, 1);
    ref_ptr = fold_addr(a);
    if (with_stop) m_stop();
    m_start();
    wbyte({DEV, 1'b1}, ak); chk("R10 read header ack", ak, 1);
    read_seq(n, "R7 R10 random read data");
    m_stop();
  endtask

  task automatic current_read(input int n, input string tag);
    logic ak;
    m_start();
    wbyte({DEV, 1'b1}, ak); chk("R3 read header ack", ak, 1);
    read_seq(n, tag);
    m_stop();
  endtask

  initial begin
    logic ak;
    logic [7:0] b;
    int hi_seen;
    void'($urandom(32'd24681));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    ref_ptr = 8'h00;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", sda_oe, 0);

    // R1: pointer 0 and zero content, via current read
    current_read(2, "R1 R9 reset content at pointer 0");
    // R1 R10: random read without stop
    random_read(16'h0010, 2, 1'b0);

    // R4: wrong address, further bytes not acknowledged
    m_start();
    wbyte({7'h51, 1'b0}, ak); chk("R4 mismatched header nack", ak, 0);
    wbyte(8'h00, ak);         chk("R4 following byte nack", ak, 0);
    wbyte(8'h00, ak);         chk("R4 following byte nack", ak, 0);
    m_stop();
    m_start();
    wbyte({7'h2A, 1'b1}, ak); chk("R4 mismatched read header nack", ak, 0);
    rbyte(1'b1, b);           chk("R4 no data driven", b, 8'hFF);
    m_stop();
    current_read(1, "R4 R9 pointer untouched by foreign traffic");

    // R5: high byte first; high bits beyond depth ignored
    page_write(16'h7A34, 1);
    random_read(16'h0034, 1, 1'b1);

    // R11: store and wrap in the same cycle at the top address
    page_write(16'h00FE, 4);
    random_read(16'h00FE, 4, 1'b0);
    chk("R11 pointer after wrap", ref_ptr, 8'h02);
    current_read(1, "R9 R11 current read after wrap");

    // R8: after nack no more driving
    m_start();
    wbyte({DEV, 1'b1}, ak); chk("R3 read header ack", ak, 1);
    rbyte(1'b0, b); chk("R7 byte before nack", b, ref_mem[ref_ptr]);
    ref_ptr = ref_ptr + 8'd1;
    hi_seen = 0;
    for (int k = 0; k < 9; k++) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q();
      if (sda_line === 1'b1) hi_seen++;
      q(); scl_m = 1'b0; q();
    end
    chk("R8 released after master nack", hi_seen, 9);
    m_stop();

    // R2: repeated start in the middle of a write
    m_start();
    wbyte({DEV, 1'b0}, ak); chk("R3 write header ack", ak, 1);
    wbyte(8'h00, ak); wbyte(8'h40, ak); chk("R5 addr ack", ak, 1);
    ref_ptr = 8'h40;
    wbyte(8'hC3, ak); chk("R6 data ack", ak, 1);
    ref_mem[8'h40] = 8'hC3; ref_ptr = 8'h41;
    m_start();
    wbyte({DEV, 1'b1}, ak); chk("R2 header after repeated start", ak, 1);
    read_seq(2, "R2 R9 read after repeated start");
    m_stop();

    // random mix
    for (int it = 0; it < 12; it++) begin
      int op;
      op = int'($urandom_range(2, 0));
      if (op == 0)      page_write(16'($urandom), int'($urandom_range(5, 1)));
      else if (op == 1) random_read(16'($urandom), int'($urandom_range(4, 1)), 1'($urandom));
      else              current_read(int'($urandom_range(3, 1)), "R9 random current read");
    end

    chk("R12 oe change with scl high", viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule